// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Chain Sequencer

This block is the digital control core that sits in front of an eight-input successive-approximation converter. Software uses a small word-addressed register port to pick the channels to convert, set how long each channel is sampled, and launch a chain of conversions. A chain can run once or repeat until software stops it. For each enabled channel, in ascending index order, the sequencer runs four phases: precharge, sample, convert and data. During these phases it drives a channel select plus sample and convert strobes to the converter. At the end of the data phase it stores the 12-bit value the converter returns.

Each stored result sets a per-channel pending flag and a valid flag. The end of a chain raises an interrupt status bit that can be masked onto an interrupt line. A power-down bit halts all progress. A calibration request runs a fixed-length busy window and records a pass or fail outcome. Conversions cannot start while a calibration is pending or running.

Top module: `adc_chain_seq`

## Requirements
- R1: After reset, the control word (address 0) reads 0x00003901, so the block is powered down. The sample-length register (address 6) reads 0x14. The channel mask (address 5), pending flags (address 4) and interrupt status (address 2) read 0, and `irq` is low.
- R2: The channel mask register keeps only bits 7:0 of a write. Bits 31:8 read as zero.
- R3: Each channel's conversion has four phases: 2 precharge clocks, `conv_sample` high for max(L, 8) clocks where L is the sample-length register, `conv_convert` high for 56 clocks, and 2 data clocks. Consecutive channels in a chain therefore begin max(L, 8) + 60 clocks apart.
- R4: A chain converts only the channels whose mask bit was set at launch, in ascending index order. `conv_chan` shows the channel being converted.
- R5: The result for channel n reads at address 8+n. Bits 11:0 hold the value present on `conv_result` during the last data clock. Bit 19 is a valid flag: a new result sets it, and a read of that address clears it, so the read returns 1 and the next read returns 0.
- R6: When channel n's result is stored, bit n of the pending register (address 4) is set. Writing a 1 to a bit clears it. Writing a 0 leaves it unchanged.
- R7: The end of every chain sets bit 0 of the interrupt status (address 2). Writing 1 to that bit clears it. `irq` is high only while both that status bit and bit 0 of the interrupt mask (address 3) are set.
- R8: Setting control bit 24 (go) launches a chain. With control bit 29 (repeat) at 0, go clears itself when the chain finishes, and no further chain runs.
- R9: With repeat set, a new chain starts after each chain completes while go stays set. If go is cleared during a chain, that chain still converts all its channels and signals completion, and no new chain follows.
- R10: While control bit 0 (power-down) is set, no chain launches. A chain in progress freezes without storing results, and resumes when the bit is cleared. A calibration request made while powered down is dropped.
- R11: Writing control bit 14 while powered up and idle sets status bit 29 (busy) for CAL_CYCLES clocks. If `cal_ok` is low at the end, status bit 30 (fail) is set and stays set until software writes status with bit 30 at 0. Control bit 14 always reads 0.
- R12: No chain launches while a calibration request is pending or the calibration is busy. A go set in the same write as the request takes effect after the calibration ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on `bus_rdata` after the next edge |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Masked end-of-chain interrupt |
| conv_chan | output | $clog2(NCH) | Channel being converted |
| conv_sample | output | 1 | Sample-phase strobe to the converter |
| conv_convert | output | 1 | Conversion-phase strobe to the converter |
| conv_result | input | DW | Converter output, captured in the last data clock |
| cal_ok | input | 1 | Calibration outcome, sampled on the final busy clock |

## Verification
The assertions assume four things about the environment:
- software never asserts `bus_wr` and `bus_rd` in the same cycle;
- `conv_result` is settled by the last data clock of each channel;
- reset is held for at least one clock edge;
- no write changes the control word in the same cycle a one-shot chain ends.

The bench keeps within these assumptions in the following ways. It drives every bus access from a task, one strobe per cycle, on the falling edge. Its converter stub returns a value computed only from `conv_chan`, so that value is steady for the whole channel. It issues control writes only while idle, or mid-sample, well away from the end of a chain.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_PRE, PH_SAMP, PH_CONV, PH_DATA} phase_t;

  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_ISR  = 2;
  localparam int A_IMR  = 3;
  localparam int A_EOC  = 4;
  localparam int A_MASK = 5;
  localparam int A_SAMP = 6;

  localparam int B_PWDN  = 0;
  localparam int B_CAL   = 14;
  localparam int B_GO    = 24;
  localparam int B_MODE  = 29;
  localparam int B_BUSY  = 29;
  localparam int B_FAIL  = 30;
  localparam int B_VALID = 19;

  localparam logic [31:0] CTRL_RST = 32'h0000_3901;
endpackage

// File: rtl/adc_seq_cal.sv
module adc_seq_cal #(
  parameter int CAL_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic pwdn,
  input  logic chain_active,
  input  logic cal_ok,
  input  logic fail_clr,
  output logic busy,
  output logic fail
);
  localparam int CC_W = $clog2(CAL_CYCLES + 1);

  logic [CC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      fail  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (fail_clr) fail <= 1'b0;
      if (!busy) begin
        if (req && !pwdn && !chain_active) begin
          busy  <= 1'b1;
          cnt_q <= CC_W'(CAL_CYCLES - 1);
        end
      end else if (!pwdn) begin
        if (cnt_q == '0) begin
          busy <= 1'b0;
          if (!cal_ok) fail <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R11
  cal_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && pwdn) |=> (busy && $stable(cnt_q)));

  // R10
  cal_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (req && pwdn && !busy) |=> !busy);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int DW       = 12,
  parameter int SL_W     = 8,
  parameter int MIN_SAMP = 8,
  parameter int PRE_CYC  = 2,
  parameter int CONV_CYC = 56,
  parameter int DATA_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go,
  input  logic                     pwdn,
  input  logic                     hold,
  input  logic [NCH-1:0]           en_mask,
  input  logic [SL_W-1:0]          samp_len,
  input  logic [DW-1:0]            conv_result,
  output logic [$clog2(NCH)-1:0]   conv_chan,
  output logic                     conv_sample,
  output logic                     conv_convert,
  output logic                     active,
  output logic                     res_we,
  output logic [$clog2(NCH)-1:0]   res_ch,
  output logic [DW-1:0]            res_data,
  output logic                     chain_done
);
  localparam int CW    = $clog2(NCH);
  localparam int CV_W  = $clog2(CONV_CYC + 1);
  localparam int CNT_W = (SL_W > CV_W) ? SL_W : CV_W;

  phase_t          ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NCH-1:0]   todo_q;
  logic [CW-1:0]    cur;
  logic [NCH-1:0]   rest;
  logic [SL_W-1:0]  samp_eff;
  logic             adv, ph_end, launch, ch_end;

  always_comb begin
    cur = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (todo_q[i]) cur = CW'(i);
  end

  assign rest     = todo_q & ~(NCH'(1) << cur);
  assign samp_eff = (samp_len < SL_W'(MIN_SAMP)) ? SL_W'(MIN_SAMP) : samp_len;
  assign adv      = !pwdn;
  assign ph_end   = (cnt_q == '0);
  assign launch   = (ph_q == PH_IDLE) && go && !pwdn && !hold && (|en_mask);
  assign ch_end   = (ph_q == PH_DATA) && adv && ph_end;

  assign chain_done   = ch_end && (rest == '0);
  assign res_we       = ch_end;
  assign res_ch       = cur;
  assign res_data     = conv_result;
  assign conv_chan    = cur;
  assign conv_sample  = (ph_q == PH_SAMP);
  assign conv_convert = (ph_q == PH_CONV);
  assign active       = (ph_q != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      todo_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (launch) begin
          ph_q   <= PH_PRE;
          cnt_q  <= CNT_W'(PRE_CYC - 1);
          todo_q <= en_mask;
        end
        PH_PRE: if (adv) begin
          if (ph_end) begin
            ph_q  <= PH_SAMP;
            cnt_q <= CNT_W'(samp_eff) - 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_SAMP: if (adv) begin
          if (ph_end) begin
            ph_q  <= PH_CONV;
            cnt_q <= CNT_W'(CONV_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_CONV: if (adv) begin
          if (ph_end) begin
            ph_q  <= PH_DATA;
            cnt_q <= CNT_W'(DATA_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_DATA: if (adv) begin
          if (ph_end) begin
            todo_q <= rest;
            if (rest == '0) ph_q <= PH_IDLE;
            else begin
              ph_q  <= PH_PRE;
              cnt_q <= CNT_W'(PRE_CYC - 1);
            end
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (pwdn && ph_q != PH_IDLE) |=> ($stable(ph_q) && $stable(cnt_q)));

  // R3
  samp_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_q == PH_SAMP) |-> (cnt_q >= CNT_W'(MIN_SAMP - 1)));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && ph_q == PH_IDLE) |=> (ph_q == PH_IDLE));

  // R4
  chan_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE && !ch_end) |=> $stable(cur));

  // R4
  ascend_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_end && rest != '0) |=> (cur > $past(cur)));
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int DW       = 12,
  parameter int SL_W     = 8,
  parameter int ADDR_W   = 4,
  parameter int SAMP_RST = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   irq,
  output logic                   go,
  output logic                   pwdn,
  output logic [NCH-1:0]         en_mask,
  output logic [SL_W-1:0]        samp_len,
  output logic                   cal_req,
  output logic                   fail_clr,
  input  logic                   res_we,
  input  logic [$clog2(NCH)-1:0] res_ch,
  input  logic [DW-1:0]          res_data,
  input  logic                   chain_done,
  input  logic                   cal_busy,
  input  logic                   cal_fail
);
  localparam int CW = $clog2(NCH);

  logic [31:0]    ctrl_q;
  logic [NCH-1:0] mask_q, eoc_q, valid_q;
  logic [SL_W-1:0] samp_q;
  logic           imr_q, isr_q, cal_req_q;
  logic [DW-1:0]  res_mem [NCH];
  logic [DW-1:0]  mem_rd;
  logic [31:0]    rd_word;
  logic           is_res, wr_ctrl, wr_stat, wr_isr, wr_eoc;
  logic [CW-1:0]  rd_idx;
  logic [NCH-1:0] set_vec, clr_vec, rdclr_vec;

  assign is_res  = bus_addr[ADDR_W-1];
  assign rd_idx  = bus_addr[CW-1:0];
  assign wr_ctrl = bus_wr && bus_addr == ADDR_W'(A_CTRL);
  assign wr_stat = bus_wr && bus_addr == ADDR_W'(A_STAT);
  assign wr_isr  = bus_wr && bus_addr == ADDR_W'(A_ISR);
  assign wr_eoc  = bus_wr && bus_addr == ADDR_W'(A_EOC);

  assign set_vec   = res_we ? (NCH'(1) << res_ch) : '0;
  assign clr_vec   = wr_eoc ? bus_wdata[NCH-1:0] : '0;
  assign rdclr_vec = (bus_rd && is_res) ? (NCH'(1) << rd_idx) : '0;

  assign go       = ctrl_q[B_GO];
  assign pwdn     = ctrl_q[B_PWDN];
  assign en_mask  = mask_q;
  assign samp_len = samp_q;
  assign cal_req  = cal_req_q;
  assign fail_clr = wr_stat && !bus_wdata[B_FAIL];

  always_ff @(posedge clk) begin
    if (res_we) res_mem[res_ch] <= res_data;
  end
  assign mem_rd = res_mem[rd_idx];

  always_comb begin
    rd_word = '0;
    if (is_res) begin
      rd_word[DW-1:0] = mem_rd;
      rd_word[B_VALID] = valid_q[rd_idx];
    end else begin
      case (bus_addr)
        ADDR_W'(A_CTRL): rd_word = ctrl_q;
        ADDR_W'(A_STAT): begin
          rd_word[B_BUSY] = cal_busy;
          rd_word[B_FAIL] = cal_fail;
        end
        ADDR_W'(A_ISR):  rd_word[0] = isr_q;
        ADDR_W'(A_IMR):  rd_word[0] = imr_q;
        ADDR_W'(A_EOC):  rd_word[NCH-1:0] = eoc_q;
        ADDR_W'(A_MASK): rd_word[NCH-1:0] = mask_q;
        ADDR_W'(A_SAMP): rd_word[SL_W-1:0] = samp_q;
        default:         rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_RST;
      mask_q    <= '0;
      samp_q    <= SL_W'(SAMP_RST);
      imr_q     <= 1'b0;
      isr_q     <= 1'b0;
      eoc_q     <= '0;
      valid_q   <= '0;
      cal_req_q <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      cal_req_q <= wr_ctrl && bus_wdata[B_CAL];
      if (wr_ctrl) begin
        ctrl_q <= bus_wdata;
        ctrl_q[B_CAL] <= 1'b0;
      end
      if (chain_done && !ctrl_q[B_MODE]) ctrl_q[B_GO] <= 1'b0;
      if (bus_wr && bus_addr == ADDR_W'(A_MASK)) mask_q <= bus_wdata[NCH-1:0];
      if (bus_wr && bus_addr == ADDR_W'(A_SAMP)) samp_q <= bus_wdata[SL_W-1:0];
      if (bus_wr && bus_addr == ADDR_W'(A_IMR))  imr_q  <= bus_wdata[0];
      if (chain_done) isr_q <= 1'b1;
      else if (wr_isr && bus_wdata[0]) isr_q <= 1'b0;
      eoc_q   <= (eoc_q & ~clr_vec) | set_vec;
      valid_q <= (valid_q & ~rdclr_vec) | set_vec;
      irq     <= isr_q & imr_q;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end

  // R6
  eoc_set_chk: assert property (@(posedge clk) disable iff (rst)
    res_we |=> eoc_q[$past(res_ch)]);

  // R5
  valid_set_chk: assert property (@(posedge clk) disable iff (rst)
    res_we |=> valid_q[$past(res_ch)]);

  // R7
  isr_set_chk: assert property (@(posedge clk) disable iff (rst)
    chain_done |=> isr_q);

  // R8
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (chain_done && !ctrl_q[B_MODE] && !wr_ctrl) |=> !ctrl_q[B_GO]);
endmodule

// File: rtl/adc_chain_seq.sv
module adc_chain_seq #(
  parameter int NCH        = 8,
  parameter int DW         = 12,
  parameter int SL_W       = 8,
  parameter int ADDR_W     = 4,
  parameter int CAL_CYCLES = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   irq,
  output logic [$clog2(NCH)-1:0] conv_chan,
  output logic                   conv_sample,
  output logic                   conv_convert,
  input  logic [DW-1:0]          conv_result,
  input  logic                   cal_ok
);
  localparam int CW = $clog2(NCH);

  logic           go, pwdn, cal_req, fail_clr, cal_busy, cal_fail;
  logic           res_we, chain_done, active;
  logic [NCH-1:0] en_mask;
  logic [SL_W-1:0] samp_len;
  logic [CW-1:0]  res_ch;
  logic [DW-1:0]  res_data;

  adc_seq_regs #(.NCH(NCH), .DW(DW), .SL_W(SL_W), .ADDR_W(ADDR_W), .SAMP_RST(20)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .go(go), .pwdn(pwdn),
    .en_mask(en_mask), .samp_len(samp_len), .cal_req(cal_req), .fail_clr(fail_clr),
    .res_we(res_we), .res_ch(res_ch), .res_data(res_data), .chain_done(chain_done),
    .cal_busy(cal_busy), .cal_fail(cal_fail)
  );

  adc_seq_ctrl #(.NCH(NCH), .DW(DW), .SL_W(SL_W)) u_ctrl (
    .clk(clk), .rst(rst), .go(go), .pwdn(pwdn), .hold(cal_busy | cal_req),
    .en_mask(en_mask), .samp_len(samp_len), .conv_result(conv_result),
    .conv_chan(conv_chan), .conv_sample(conv_sample), .conv_convert(conv_convert),
    .active(active), .res_we(res_we), .res_ch(res_ch), .res_data(res_data),
    .chain_done(chain_done)
  );

  adc_seq_cal #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk(clk), .rst(rst), .req(cal_req), .pwdn(pwdn), .chain_active(active),
    .cal_ok(cal_ok), .fail_clr(fail_clr), .busy(cal_busy), .fail(cal_fail)
  );
endmodule

// File: tb/adc_chain_seq_bench.sv
module adc_chain_seq_bench;
  localparam int CAL = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, conv_sample, conv_convert;
  logic [2:0]  conv_chan;
  logic [11:0] conv_result;
  logic        cal_ok = 1'b1;

  int total = 0, bad = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  assign conv_result = {1'b0, conv_chan, 8'h5A};

  adc_chain_seq #(.CAL_CYCLES(CAL)) u_adc_chain_seq (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .conv_chan(conv_chan),
    .conv_sample(conv_sample), .conv_convert(conv_convert),
    .conv_result(conv_result), .cal_ok(cal_ok)
  );

  // monitor of converter strobes
  int   nr = 0, since_rise = 0, gap_last = 0;
  int   s_run = 0, s_last = 0, c_run = 0, c_last = 0;
  logic prev_s = 1'b0, prev_c = 1'b0;
  logic [2:0] order [64];

  always @(negedge clk) begin
    if (conv_sample && !prev_s) begin
      if (nr < 64) order[nr] = conv_chan;
      nr = nr + 1;
      gap_last = since_rise;
      since_rise = 1;
    end else since_rise = since_rise + 1;
    if (conv_sample) s_run = s_run + 1;
    else if (prev_s) begin s_last = s_run; s_run = 0; end
    if (conv_convert) c_run = c_run + 1;
    else if (prev_c) begin c_last = c_run; c_run = 0; end
    prev_s = conv_sample;
    prev_c = conv_convert;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1'b1; break; end
    end
    check(req, 32'(seen), 32'd1);
  endtask

  task automatic wait_sampling();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (conv_sample) break;
    end
  endtask

  task automatic t_reset();
    rdreg(4'd0, rd); check("R1 ctrl", rd, 32'h0000_3901);
    rdreg(4'd6, rd); check("R1 samp", rd, 32'h14);
    rdreg(4'd5, rd); check("R1 mask", rd, 32'h0);
    rdreg(4'd4, rd); check("R1 eoc", rd, 32'h0);
    rdreg(4'd2, rd); check("R1 isr", rd, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_mask();
    wr(4'd5, 32'hFFFF_FFA5);
    rdreg(4'd5, rd); check("R2 mask upper bits", rd, 32'h0000_00A5);
  endtask

  task automatic t_powerdown();
    int n0;
    n0 = nr;
    wr(4'd5, 32'h01);
    wr(4'd0, 32'h0100_3901);
    idle(200);
    check("R10 no launch while down", 32'(nr - n0), 32'd0);
    rdreg(4'd4, rd); check("R10 no result while down", rd, 32'h0);
    wr(4'd0, 32'h0100_7901);
    idle(5);
    rdreg(4'd1, rd); check("R10 cal dropped while down", rd, 32'h0);
    wr(4'd0, 32'h0000_3901);
  endtask

  task automatic t_single();
    int n0;
    wr(4'd6, 32'h3);
    wr(4'd5, 32'h25);
    wr(4'd3, 32'h1);
    n0 = nr;
    wr(4'd0, 32'h0100_3900);
    wait_irq("R7 irq at chain end");
    check("R4 count", 32'(nr - n0), 32'd3);
    check("R4 first", 32'(order[n0]), 32'd0);
    check("R4 second", 32'(order[n0+1]), 32'd2);
    check("R4 third", 32'(order[n0+2]), 32'd5);
    check("R3 sample clamp", 32'(s_last), 32'd8);
    check("R3 convert len", 32'(c_last), 32'd56);
    check("R3 channel spacing", 32'(gap_last), 32'd68);
    rdreg(4'd4, rd); check("R6 pending", rd, 32'h25);
    rdreg(4'd2, rd); check("R7 isr", rd, 32'h1);
    rdreg(4'd0, rd); check("R8 go cleared", rd, 32'h0000_3900);
    rdreg(4'd10, rd); check("R5 result ch2", rd, 32'h0008_025A);
    rdreg(4'd10, rd); check("R5 valid cleared by read", rd, 32'h0000_025A);
    rdreg(4'd9, rd); check("R5 unconverted not valid", rd & 32'h0008_0000, 32'h0);
    wr(4'd4, 32'h04);
    rdreg(4'd4, rd); check("R6 w1c", rd, 32'h21);
    wr(4'd4, 32'h00);
    rdreg(4'd4, rd); check("R6 zero write no effect", rd, 32'h21);
    n0 = nr;
    idle(300);
    check("R8 no second chain", 32'(nr - n0), 32'd0);
    wr(4'd3, 32'h0);
    idle(2);
    check("R7 irq masked", 32'(irq), 32'h0);
    rdreg(4'd2, rd); check("R7 status kept when masked", rd, 32'h1);
    wr(4'd3, 32'h1);
    wr(4'd2, 32'h1);
    idle(2);
    check("R7 irq after clear", 32'(irq), 32'h0);
    wr(4'd4, 32'hFF);
  endtask

  task automatic t_repeat();
    int n0;
    wr(4'd6, 32'd20);
    wr(4'd5, 32'h81);
    wr(4'd0, 32'h2100_3900);
    wait_irq("R9 first chain");
    check("R3 long sample", 32'(s_last), 32'd20);
    check("R3 long spacing", 32'(gap_last), 32'd80);
    wr(4'd2, 32'h1);
    wr(4'd4, 32'hFF);
    wait_irq("R9 repeated chain");
    wr(4'd2, 32'h1);
    wr(4'd4, 32'hFF);
    wait_sampling();
    wr(4'd0, 32'h2000_3900);
    wait_irq("R9 chain finishes after go cleared");
    rdreg(4'd4, rd); check("R9 all channels done", rd, 32'h81);
    wr(4'd2, 32'h1);
    wr(4'd4, 32'hFF);
    n0 = nr;
    idle(400);
    check("R9 no new chain", 32'(nr - n0), 32'd0);
    check("R9 irq stays low", 32'(irq), 32'h0);
  endtask

  task automatic t_freeze();
    wr(4'd5, 32'h02);
    wr(4'd6, 32'h8);
    wr(4'd0, 32'h0100_3900);
    wait_sampling();
    wr(4'd0, 32'h0100_3901);
    idle(300);
    rdreg(4'd4, rd); check("R10 frozen no result", rd, 32'h0);
    check("R10 frozen no irq", 32'(irq), 32'h0);
    wr(4'd0, 32'h0100_3900);
    wait_irq("R10 resumes");
    rdreg(4'd4, rd); check("R10 result after resume", rd, 32'h02);
    wr(4'd2, 32'h1);
    wr(4'd4, 32'hFF);
  endtask

  task automatic t_cal();
    int n0;
    wr(4'd5, 32'h01);
    cal_ok = 1'b0;
    n0 = nr;
    wr(4'd0, 32'h0100_7900);
    idle(3);
    rdreg(4'd1, rd); check("R11 busy", rd, 32'h2000_0000);
    idle(CAL - 12);
    check("R12 no launch during cal", 32'(nr - n0), 32'd0);
    wait_irq("R12 chain after cal");
    rdreg(4'd1, rd); check("R11 fail sticky", rd, 32'h4000_0000);
    rdreg(4'd0, rd); check("R11 cal bit reads 0", rd, 32'h0000_3900);
    wr(4'd1, 32'h0);
    rdreg(4'd1, rd); check("R11 fail cleared", rd, 32'h0);
    cal_ok = 1'b1;
    wr(4'd0, 32'h0000_7900);
    idle(CAL + 6);
    rdreg(4'd1, rd); check("R11 pass no fail", rd, 32'h0);
    wr(4'd2, 32'h1);
    wr(4'd4, 32'hFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mask();
    t_powerdown();
    t_single();
    t_repeat();
    t_freeze();
    t_cal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule